// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

This block is the operate stage of a small register-transfer datapath. Two operands, `x_in` and `y_in`, enter it together with a group selector, a three-line operation code and a width line. It drives a result `z_out` without any pipeline delay. A single carry/borrow flag is kept in a register that updates on the rising clock edge.

Six arithmetic operations share one ripple adder. These are add, add with carry, subtract, subtract with borrow, increment and decrement. The adder gets its second operand through a gate and a conditional inverter, and its carry-in through a small selector. The logic group offers four bitwise functions.

Shift operations are computed by a neighbouring block. Their result and the bit they shift out are passed through this block. In byte mode only the low half of the datapath counts: the flag comes from the carry out of the low half, and the high half of the result reads zero.

Top module: `mode_alu`

## Requirements
- R1: `grp_sel` picks the group: 2'b00 logic, 2'b01 arithmetic, 2'b10 shift. For 2'b11, `z_out` is all zeros.
- R2: In the arithmetic group, `op_sel` is {src, inv, cin}, with bit 2 the operand source, bit 1 the inversion and bit 0 the carry selection. Code 3'b100 gives X+Y, and code 3'b110 gives X−Y, both modulo the active width.
- R3: After an arithmetic operation, `cf_out` holds the carry out of the active width for additions. For subtraction and decrement it holds the borrow: 1 exactly when the unsigned result went below zero.
- R4: Code 3'b101 gives X+Y+F and code 3'b111 gives X−Y−F, where F is the flag value before the edge.
- R5: Code 3'b001 gives X+1 and code 3'b011 gives X−1, and `y_in` has no effect on either the result or the flag.
- R6: In the logic group, `op_sel[1:0]` selects the function: 2'b00 gives X AND Y, 2'b01 gives X XOR Y, 2'b10 gives X OR Y, and 2'b11 gives NOT X. `op_sel[2]` is ignored.
- R7: When `grp_sel` is 2'b00 or 2'b11, `cf_out` keeps its value across the clock edge.
- R8: In the shift group, `z_out` equals `shift_res`, and `cf_out` loads `shift_cout` on the clock edge.
- R9: With `wide` low, only bits 7..0 of the operands take part. The flag comes from the carry or borrow of bit 7, and bits 15..8 of `z_out` are zero.
- R10: A synchronous active-high `rst` clears `cf_out` on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| grp_sel | input | 2 | Group selector: logic, arithmetic, shift, unused |
| op_sel | input | 3 | Operation code within the group |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| shift_res | input | 16 | Result from the external shift block |
| shift_cout | input | 1 | Bit shifted out by the external shift block |
| z_out | output | 16 | Result |
| cf_out | output | 1 | Stored carry/borrow flag |

## Verification
Several properties are checked on every cycle:
- the zero result for the unused group code;
- the zero high half in byte mode;
- the shift pass-through and shift flag load;
- the held flag for logic and unused groups;
- the 16-bit add result;
- the reset clearing the flag.

Other behaviours can only be shown by the bench's directed scenarios, because they depend on a flag value prepared by an earlier operation. These are the borrow polarity, the chained add-with-carry and subtract-with-borrow, Y having no influence on increment and decrement, and the bit-7 flag source in byte mode.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;

    localparam int unsigned HALF_W_DEF = 8;

    typedef enum logic [1:0] {
        GRP_LOGIC = 2'b00,
        GRP_ARITH = 2'b01,
        GRP_SHIFT = 2'b10,
        GRP_NONE  = 2'b11
    } grp_e;

    // Arithmetic control lines as carried in op_sel
    typedef struct packed {
        logic src_y;   // 1: Y feeds the adder, 0: Y path forced to zero
        logic inv;     // 1: invert Y path and flag (subtract family)
        logic chain;   // carry-in selection
    } arith_ctl_t;

    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_XOR  = 2'b01,
        LG_OR   = 2'b10,
        LG_NOTX = 2'b11
    } logic_fn_e;

    // Carry-in of the shared adder
    function automatic logic adder_cin(arith_ctl_t c, logic flag);
        if (c.chain) begin
            if (c.src_y) return flag ^ c.inv;   // chained carry or inverted borrow
            else         return ~c.inv;         // increment +1, decrement +0
        end
        return c.inv;                           // +1 of the two's complement
    endfunction

endpackage

// File: rtl/mode_alu_arith.sv
module mode_alu_arith
    import mode_alu_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input  logic [2*HALF_W-1:0] x,
    input  logic [2*HALF_W-1:0] y,
    input  arith_ctl_t          ctl,
    input  logic                wide,
    input  logic                flag_in,
    output logic [2*HALF_W-1:0] sum,
    output logic                flag_next
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] y_gate;
    logic [FULL_W-1:0] y_eff;
    logic [FULL_W:0]   cy;
    logic              cout_sel;

    always_comb begin
        y_gate = ctl.src_y ? y : '0;
        y_eff  = y_gate ^ {FULL_W{ctl.inv}};
    end

    assign cy[0] = adder_cin(ctl, flag_in);

    for (genvar i = 0; i < FULL_W; i++) begin : g_fa
        assign sum[i]  = x[i] ^ y_eff[i] ^ cy[i];
        assign cy[i+1] = (x[i] & y_eff[i]) | (x[i] & cy[i]) | (y_eff[i] & cy[i]);
    end

    always_comb begin
        cout_sel  = wide ? cy[FULL_W] : cy[HALF_W];
        flag_next = cout_sel ^ ctl.inv;
    end

endmodule

// File: rtl/mode_alu_logic.sv
module mode_alu_logic
    import mode_alu_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input  logic [2*HALF_W-1:0] x,
    input  logic [2*HALF_W-1:0] y,
    input  logic_fn_e           fn,
    output logic [2*HALF_W-1:0] res
);
    always_comb begin
        unique case (fn)
            LG_AND:  res = x & y;
            LG_XOR:  res = x ^ y;
            LG_OR:   res = x | y;
            LG_NOTX: res = ~x;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mode_alu_flag.sv
module mode_alu_flag (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/mode_alu.sv
module mode_alu
    import mode_alu_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*HALF_W-1:0] x_in,
    input  logic [2*HALF_W-1:0] y_in,
    input  logic [1:0]          grp_sel,
    input  logic [2:0]          op_sel,
    input  logic                wide,
    input  logic [2*HALF_W-1:0] shift_res,
    input  logic                shift_cout,
    output logic [2*HALF_W-1:0] z_out,
    output logic                cf_out
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    grp_e              grp;
    arith_ctl_t        actl;
    logic_fn_e         lfn;
    logic [FULL_W-1:0] x_m, y_m;
    logic [FULL_W-1:0] arith_z, logic_z, z_raw;
    logic              arith_flag;
    logic              flag_load, flag_d;
    logic [FULL_W-1:0] width_mask;

    always_comb begin
        grp        = grp_e'(grp_sel);
        actl       = arith_ctl_t'(op_sel);
        lfn        = logic_fn_e'(op_sel[1:0]);
        width_mask = wide ? {FULL_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        x_m        = x_in & width_mask;
        y_m        = y_in & width_mask;
    end

    mode_alu_arith #(.HALF_W(HALF_W)) i_arith (
        .x         (x_m),
        .y         (y_m),
        .ctl       (actl),
        .wide      (wide),
        .flag_in   (cf_out),
        .sum       (arith_z),
        .flag_next (arith_flag)
    );

    mode_alu_logic #(.HALF_W(HALF_W)) i_logic (
        .x   (x_m),
        .y   (y_m),
        .fn  (lfn),
        .res (logic_z)
    );

    always_comb begin
        unique case (grp)
            GRP_LOGIC: z_raw = logic_z;
            GRP_ARITH: z_raw = arith_z;
            GRP_SHIFT: z_raw = shift_res;
            default:   z_raw = '0;
        endcase
        z_out     = z_raw & width_mask;
        flag_load = (grp == GRP_ARITH) || (grp == GRP_SHIFT);
        flag_d    = (grp == GRP_ARITH) ? arith_flag : shift_cout;
    end

    mode_alu_flag i_flag (
        .clk  (clk),
        .rst  (rst),
        .load (flag_load),
        .d    (flag_d),
        .q    (cf_out)
    );

endmodule

// File: rtl/mode_alu_chk.sv
module mode_alu_chk
    import mode_alu_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input logic                clk,
    input logic                rst,
    input logic [2*HALF_W-1:0] x_in,
    input logic [2*HALF_W-1:0] y_in,
    input logic [1:0]          grp_sel,
    input logic [2:0]          op_sel,
    input logic                wide,
    input logic [2*HALF_W-1:0] shift_res,
    input logic                shift_cout,
    input logic [2*HALF_W-1:0] z_out,
    input logic                cf_out
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (grp_sel == 2'b11) |-> (z_out == '0));

    p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (grp_sel == 2'b01 && op_sel == 3'b100 && wide) |-> (z_out == FULL_W'(x_in + y_in)));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (grp_sel == 2'b00 || grp_sel == 2'b11) |=> $stable(cf_out));

    p_shift_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (grp_sel == 2'b10 && wide) |-> (z_out == shift_res));

    p_shift_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (grp_sel == 2'b10) |=> (cf_out == $past(shift_cout)));

    p_narrow_upper_r9: assert property (@(posedge clk) disable iff (rst)
        !wide |-> (z_out[FULL_W-1:HALF_W] == '0));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !cf_out);

endmodule

bind mode_alu mode_alu_chk #(.HALF_W(HALF_W)) i_chk (.*);

// File: tb/test_mode_alu.sv
module test_mode_alu;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] x_in = '0, y_in = '0, shift_res = '0;
    logic [1:0]  grp_sel = 2'b00;
    logic [2:0]  op_sel = 3'b000;
    logic        wide = 1'b1;
    logic        shift_cout = 1'b0;
    logic [15:0] z_out;
    logic        cf_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic cf_model = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mode_alu i_mode_alu (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] g, input logic [2:0] op, input logic w,
                         input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        grp_sel = g; op_sel = op; wide = w; x_in = x; y_in = y;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reference arithmetic from the requirements
    task automatic arith_op(input string tag, input logic [2:0] op, input logic w,
                            input logic [15:0] x, input logic [15:0] y);
        int mask, xm, ym, t;
        logic f;
        mask = w ? 32'hFFFF : 32'hFF;
        xm = int'(x) & mask;
        ym = int'(y) & mask;
        f  = cf_model;
        case (op)
            3'b100: begin t = xm + ym;        f = t > mask; end
            3'b101: begin t = xm + ym + int'(cf_model); f = t > mask; end
            3'b110: begin t = xm - ym;        f = xm < ym; end
            3'b111: begin t = xm - ym - int'(cf_model); f = xm < ym + int'(cf_model); end
            3'b001: begin t = xm + 1;         f = t > mask; end
            3'b011: begin t = xm - 1;         f = xm == 0; end
            default: t = xm;
        endcase
        drive(2'b01, op, w, x, y);
        chk({tag, " result"}, {16'h0, z_out}, t & mask);
        tick();
        cf_model = f;
        chk({tag, " flag"}, {31'h0, cf_out}, {31'h0, f});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R10 flag after reset", {31'h0, cf_out}, 32'h0);
        @(negedge clk); rst = 1'b0;
        cf_model = 1'b0;
    endtask

    task automatic t_add();
        arith_op("R2 add", 3'b100, 1'b1, 16'h1234, 16'h0F0F);
        arith_op("R3 add carry", 3'b100, 1'b1, 16'hFFFF, 16'h0001);
    endtask

    task automatic t_adc();
        arith_op("R4 adc with carry", 3'b101, 1'b1, 16'h0010, 16'h0020);
        arith_op("R4 adc no carry", 3'b101, 1'b1, 16'h8000, 16'h8000);
        arith_op("R4 adc carry set", 3'b101, 1'b1, 16'h0001, 16'hFFFF);
    endtask

    task automatic t_sub();
        arith_op("R3 sub borrow", 3'b110, 1'b1, 16'h0005, 16'h0007);
        arith_op("R2 sub", 3'b110, 1'b1, 16'h0100, 16'h0001);
    endtask

    task automatic t_sbb();
        arith_op("R3 sub prep", 3'b110, 1'b1, 16'h0001, 16'h0002);
        arith_op("R4 sbb borrow in", 3'b111, 1'b1, 16'h0010, 16'h0003);
        arith_op("R4 sbb clear", 3'b111, 1'b1, 16'h0000, 16'h0000);
        arith_op("R3 sub prep2", 3'b110, 1'b1, 16'h0000, 16'h0001);
        arith_op("R4 sbb wrap", 3'b111, 1'b1, 16'h0000, 16'h0000);
    endtask

    task automatic t_incdec();
        arith_op("R5 inc", 3'b001, 1'b1, 16'h00FF, 16'h1234);
        arith_op("R5 inc wrap", 3'b001, 1'b1, 16'hFFFF, 16'hAAAA);
        arith_op("R5 dec", 3'b011, 1'b1, 16'h0100, 16'h5555);
        arith_op("R5 dec zero", 3'b011, 1'b1, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_logic();
        logic [15:0] x, y;
        x = 16'h5A3C; y = 16'h0FF0;
        arith_op("R7 prep", 3'b100, 1'b1, 16'hFFFF, 16'h0001); // flag = 1
        drive(2'b00, 3'b000, 1'b1, x, y);
        chk("R6 and", {16'h0, z_out}, {16'h0, x & y});
        drive(2'b00, 3'b101, 1'b1, x, y);
        chk("R6 xor", {16'h0, z_out}, {16'h0, x ^ y});
        drive(2'b00, 3'b010, 1'b1, x, y);
        chk("R6 or", {16'h0, z_out}, {16'h0, x | y});
        drive(2'b00, 3'b111, 1'b1, x, y);
        chk("R6 not", {16'h0, z_out}, {16'h0, ~x});
        tick();
        chk("R7 flag held logic", {31'h0, cf_out}, 32'h1);
        drive(2'b11, 3'b100, 1'b1, x, y);
        chk("R1 unused zero", {16'h0, z_out}, 32'h0);
        tick();
        chk("R7 flag held unused", {31'h0, cf_out}, 32'h1);
    endtask

    task automatic t_shift();
        @(negedge clk); shift_res = 16'hA5A5; shift_cout = 1'b0;
        drive(2'b10, 3'b000, 1'b1, 16'h1111, 16'h2222);
        chk("R8 shift pass", {16'h0, z_out}, 32'hA5A5);
        tick();
        chk("R8 shift flag 0", {31'h0, cf_out}, 32'h0);
        @(negedge clk); shift_cout = 1'b1;
        tick();
        chk("R8 shift flag 1", {31'h0, cf_out}, 32'h1);
        cf_model = 1'b1;
    endtask

    task automatic t_narrow();
        arith_op("R9 narrow add", 3'b100, 1'b0, 16'h12F0, 16'h3420);
        arith_op("R9 narrow sub", 3'b110, 1'b0, 16'h7710, 16'h0020);
        arith_op("R9 narrow sub nb", 3'b110, 1'b0, 16'h0030, 16'hFF20);
        drive(2'b00, 3'b011, 1'b0, 16'hABF0, 16'h0000);
        chk("R9 narrow not", {16'h0, z_out}, 32'h000F);
        @(negedge clk); shift_res = 16'hABCD;
        drive(2'b10, 3'b000, 1'b0, 16'h0, 16'h0);
        chk("R9 narrow shift", {16'h0, z_out}, 32'h00CD);
        tick();
        cf_model = shift_cout;
    endtask

    task automatic t_reset_mid();
        arith_op("R10 prep", 3'b100, 1'b1, 16'hFFFF, 16'hFFFF);
        @(negedge clk); rst = 1'b1; grp_sel = 2'b00;
        tick();
        chk("R10 flag cleared", {31'h0, cf_out}, 32'h0);
        @(negedge clk); rst = 1'b0;
        cf_model = 1'b0;
    endtask

    initial begin
        t_reset();
        t_add();
        t_adc();
        t_sub();
        t_sbb();
        t_incdec();
        t_logic();
        t_shift();
        t_narrow();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule